// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps time of day and calendar date in packed BCD. It holds century, year, month, date, day of week, hours (24-hour), minutes and seconds. It advances once per second and corrects month lengths and leap years by itself. The block has two register sets. A hidden counting set holds the live count. A host-visible set is read and written over a 4-bit address and 8-bit data port.

The oscillator prescaler is modelled as an `osc_tick` strobe. `SUBTICKS` strobes make one second. On each second the counting set steps, and the visible set takes the new count unless software has frozen it.

Software uses two control bits to work with the count:
- A freeze bit holds the visible copy steady for a consistent read. Counting carries on underneath.
- A load bit opens the visible time fields for writing. Clearing the load bit moves the written values into the counting set and restarts the sub-second phase.

A stop bit in the seconds register halts counting altogether.

Top module: `cal_clock`

## Requirements
- R1: After reset, the registers read as follows: 8h reads 00h (load and freeze clear, century 00), 9h reads 80h (stop bit set, seconds 00), minutes 00, hours 00, day 01, date 01, month 01, year 00.
- R2: The address selects one register: 8h control, 9h seconds, Ah minutes, Bh hours, Ch day of week, Dh date, Eh month, Fh year. `rd_data` shows the addressed register one clock after the address is presented. Addresses 0h–7h read 00h and ignore writes.
- R3: Bit 7 of register 9h is the stop bit. A write to 9h always updates it. While it is 1, the count does not change. While it is 0, every `SUBTICKS` pulses of `osc_tick` advance the count by one second.
- R4: Register 8h holds the load bit in bit 7, the freeze bit in bit 6 and the century in bits 5:0. A write to 8h takes the century field only when bit 7 of the written byte is 1. Writes to the time fields (9h bits 6:0, Ah–Fh) take effect only while the load bit is 1. Otherwise they are ignored.
- R5: While the load bit is 1, the visible set is not refreshed. A write to 8h that clears the load bit copies the visible set into the counting set on that clock edge and clears the sub-second phase. The next second then falls exactly `SUBTICKS` pulses later.
- R6: While the freeze bit is 1, the visible set holds the count from the moment it was set, and the counting set keeps advancing. After the freeze bit is cleared, the visible set picks up the live count at the next second step.
- R7: Seconds and minutes roll over from 59 to 00, hours roll over from 23 to 00, and the day of week wraps from 07 to 01, each carrying into the next field in BCD.
- R8: The date rolls over to 01 after 30 in April, June, September and November, and after 31 in the other months except February. Each rollover increments the month.
- R9: February ends on 29 in a leap year and on 28 otherwise. A year is a leap year if its value is a nonzero multiple of 4, or if it is 00 and the century is a multiple of 4.
- R10: Month 12 rolls over to 01 and increments the year. Year 99 rolls over to 00 and increments the century. Century 39 rolls over to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Sub-second strobe, `SUBTICKS` per second |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 4 | Register select |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for the addressed register |

## Verification
Two kinds of result are checked, and each has its own timing:
- A register read is due one clock after its address is applied. The driver task sets the address on a falling edge and queues the expected byte. The monitor compares on the next falling edge after the capturing rising edge.
- A second step lands on the rising edge inside the `SUBTICKS`-th strobe pulse after the last phase restart. Every read that depends on it is issued only after that pulse has ended. Calendar corner cases are set up through the load bit, so each of them is exactly one step away from the value being checked.

// File: rtl/cal_clock_pkg.sv
package cal_clock_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] REG_CTRL  = 4'h8;
  localparam logic [ADDR_W-1:0] REG_SEC   = 4'h9;
  localparam logic [ADDR_W-1:0] REG_MIN   = 4'hA;
  localparam logic [ADDR_W-1:0] REG_HOUR  = 4'hB;
  localparam logic [ADDR_W-1:0] REG_DOW   = 4'hC;
  localparam logic [ADDR_W-1:0] REG_DATE  = 4'hD;
  localparam logic [ADDR_W-1:0] REG_MONTH = 4'hE;
  localparam logic [ADDR_W-1:0] REG_YEAR  = 4'hF;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] mins;
    logic [7:0] secs;
  } cal_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction
endpackage

// File: rtl/cal_leap.sv
module cal_leap
  import cal_clock_pkg::*;
(
  input  logic [7:0] cent,
  input  logic [7:0] year,
  output logic       is_leap
);
  logic [6:0] year_bin;
  logic [6:0] cent_bin;

  always_comb begin
    year_bin = bcd_to_bin(year);
    cent_bin = bcd_to_bin(cent);
    if (year_bin == 7'd0) is_leap = (cent_bin[1:0] == 2'b00);
    else                  is_leap = (year_bin[1:0] == 2'b00);
  end
endmodule

// File: rtl/cal_advance.sv
module cal_advance
  import cal_clock_pkg::*;
(
  input  cal_time_t cur,
  output cal_time_t nxt
);
  logic       leap;
  logic [7:0] last_date;

  cal_leap u_leap (
    .cent    (cur.cent),
    .year    (cur.year),
    .is_leap (leap)
  );

  always_comb begin
    unique case (cur.month)
      8'h02:                      last_date = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end

  always_comb begin
    nxt = cur;
    if (cur.secs < 8'h59) begin
      nxt.secs = bcd_inc(cur.secs);
    end else begin
      nxt.secs = 8'h00;
      if (cur.mins < 8'h59) begin
        nxt.mins = bcd_inc(cur.mins);
      end else begin
        nxt.mins = 8'h00;
        if (cur.hour < 8'h23) begin
          nxt.hour = bcd_inc(cur.hour);
        end else begin
          nxt.hour = 8'h00;
          nxt.dow  = (cur.dow >= 8'h07) ? 8'h01 : bcd_inc(cur.dow);
          if (cur.date < last_date) begin
            nxt.date = bcd_inc(cur.date);
          end else begin
            nxt.date = 8'h01;
            if (cur.month < 8'h12) begin
              nxt.month = bcd_inc(cur.month);
            end else begin
              nxt.month = 8'h01;
              if (cur.year < 8'h99) begin
                nxt.year = bcd_inc(cur.year);
              end else begin
                nxt.year = 8'h00;
                nxt.cent = (cur.cent >= 8'h39) ? 8'h00 : bcd_inc(cur.cent);
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int SUBTICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic reload,
  output logic step
);
  localparam int CW = (SUBTICKS > 1) ? $clog2(SUBTICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SUBTICKS - 1);

  logic [CW-1:0] cnt;

  assign step = run && tick && !reload && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt <= '0;
    end else if (run && tick) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + CW'(1);
    end
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < SUBTICKS);

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !reload) |=> $stable(cnt));
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_clock_pkg::*;
#(
  parameter int SUBTICKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  cal_time_t int_t;
  cal_time_t ext_t;
  cal_time_t adv_t;
  logic      load_q;
  logic      frz_q;
  logic      stop_q;
  logic      step;
  logic      sel_ctrl;
  logic      sel_sec;
  logic      xfer;
  logic [DATA_W-1:0] rd_mux;

  assign sel_ctrl = wr_en && (addr == REG_CTRL);
  assign sel_sec  = wr_en && (addr == REG_SEC);
  assign xfer     = sel_ctrl && load_q && !wr_data[7];

  cal_prescaler #(.SUBTICKS(SUBTICKS)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .run    (!stop_q),
    .tick   (osc_tick),
    .reload (xfer),
    .step   (step)
  );

  cal_advance u_adv (
    .cur (int_t),
    .nxt (adv_t)
  );

  // counting set
  always_ff @(posedge clk) begin
    if (rst) begin
      int_t <= '{cent: 8'h00, year: 8'h00, month: 8'h01, date: 8'h01,
                 dow: 8'h01, hour: 8'h00, mins: 8'h00, secs: 8'h00};
    end else if (xfer) begin
      int_t <= ext_t;
    end else if (step) begin
      int_t <= adv_t;
    end
  end

  // visible set and control bits
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_t  <= '{cent: 8'h00, year: 8'h00, month: 8'h01, date: 8'h01,
                  dow: 8'h01, hour: 8'h00, mins: 8'h00, secs: 8'h00};
      load_q <= 1'b0;
      frz_q  <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      if (step && !frz_q && !load_q) ext_t <= adv_t;
      if (sel_ctrl) begin
        load_q <= wr_data[7];
        frz_q  <= wr_data[6];
        if (wr_data[7]) ext_t.cent <= {2'b00, wr_data[5:0]};
      end
      if (sel_sec) stop_q <= wr_data[7];
      if (wr_en && load_q) begin
        case (addr)
          REG_SEC:   ext_t.secs  <= {1'b0, wr_data[6:0]};
          REG_MIN:   ext_t.mins  <= wr_data;
          REG_HOUR:  ext_t.hour  <= wr_data;
          REG_DOW:   ext_t.dow   <= wr_data;
          REG_DATE:  ext_t.date  <= wr_data;
          REG_MONTH: ext_t.month <= wr_data;
          REG_YEAR:  ext_t.year  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      REG_CTRL:  rd_mux = {load_q, frz_q, ext_t.cent[5:0]};
      REG_SEC:   rd_mux = {stop_q, ext_t.secs[6:0]};
      REG_MIN:   rd_mux = ext_t.mins;
      REG_HOUR:  rd_mux = ext_t.hour;
      REG_DOW:   rd_mux = ext_t.dow;
      REG_DATE:  rd_mux = ext_t.date;
      REG_MONTH: rd_mux = ext_t.month;
      REG_YEAR:  rd_mux = ext_t.year;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (frz_q && !load_q && !sel_ctrl) |=> $stable(ext_t));

  // R4
  wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_q && !step && !(sel_ctrl && wr_data[7])) |=> $stable(ext_t));

  // R3
  osc_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !xfer) |=> $stable(int_t));

  // R5
  xfer_load_chk: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (int_t == $past(ext_t)));

  // R7
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !xfer && int_t.secs == 8'h59) |=> (int_t.secs == 8'h00));
endmodule

// File: tb/cal_clock_test.sv
module cal_clock_test;
  localparam int CLK_PERIOD = 10;
  localparam int SUBTICKS   = 4;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst;
  logic       osc_tick;
  logic       wr_en;
  logic [3:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    logic [3:0] a;
    logic [7:0] exp;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t cur_e;
  logic rd_req = 1'b0;
  logic rq_q   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_clock #(.SUBTICKS(SUBTICKS)) uut (
    .clk      (clk),
    .rst      (rst),
    .osc_tick (osc_tick),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data)
  );

  always @(posedge clk) rq_q <= rd_req;

  // monitor: compare one cycle after the address was captured
  always @(negedge clk) begin
    if (rq_q && sb_q.size() > 0) begin
      cur_e = sb_q.pop_front();
      checks++;
      if (rd_data !== cur_e.exp) begin
        fails++;
        $display("FAIL %s addr %h actual %h expected %h",
                 cur_e.tag, cur_e.a, rd_data, cur_e.exp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      fails++;
      $display("FAIL watchdog actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    addr = a; rd_req = 1'b1;
    it.a = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  // load a time through the load bit, then run exactly one second
  task automatic set_and_step(input logic [7:0] c, input logic [7:0] y,
                              input logic [7:0] mo, input logic [7:0] d,
                              input logic [7:0] dw, input logic [7:0] h,
                              input logic [7:0] m, input logic [7:0] s);
    wr(4'h8, 8'h80 | c);
    wr(4'hF, y); wr(4'hE, mo); wr(4'hD, d); wr(4'hC, dw);
    wr(4'hB, h); wr(4'hA, m); wr(4'h9, s);
    wr(4'h8, 8'h00);
    ticks(SUBTICKS);
  endtask

  initial begin
    rst = 1'b1; osc_tick = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(4'h8, 8'h00, "R1 ctrl");
    rd(4'h9, 8'h80, "R1 sec");
    rd(4'hA, 8'h00, "R1 min");
    rd(4'hB, 8'h00, "R1 hour");
    rd(4'hC, 8'h01, "R1 dow");
    rd(4'hD, 8'h01, "R1 date");
    rd(4'hE, 8'h01, "R1 month");
    rd(4'hF, 8'h00, "R1 year");

    // R2 low addresses
    wr(4'h3, 8'hAA);
    rd(4'h3, 8'h00, "R2 low addr write ignored");
    rd(4'h0, 8'h00, "R2 low addr reads zero");

    // R3 stop bit
    ticks(8);
    rd(4'h9, 8'h80, "R3 stopped");
    wr(4'h9, 8'h00);
    rd(4'h9, 8'h00, "R3 start");
    ticks(SUBTICKS);
    rd(4'h9, 8'h01, "R3 one second");
    ticks(SUBTICKS - 1);
    rd(4'h9, 8'h01, "R3 partial second");

    // R5 load with phase restart
    wr(4'h8, 8'hA0);
    wr(4'hF, 8'h24); wr(4'hE, 8'h02); wr(4'hD, 8'h28); wr(4'hC, 8'h03);
    wr(4'hB, 8'h23); wr(4'hA, 8'h59); wr(4'h9, 8'h59);
    rd(4'h9, 8'h59, "R4 write under load");
    ticks(1);
    rd(4'h9, 8'h59, "R5 no refresh under load");
    ticks(2);
    wr(4'h8, 8'h00);
    ticks(SUBTICKS - 1);
    rd(4'h9, 8'h59, "R5 phase restarted");
    ticks(1);
    rd(4'h9, 8'h00, "R5 first second");
    rd(4'hA, 8'h00, "R7 min wrap");
    rd(4'hB, 8'h00, "R7 hour wrap");
    rd(4'hD, 8'h29, "R9 leap feb 29");
    rd(4'hE, 8'h02, "R9 month held");
    rd(4'hC, 8'h04, "R7 dow inc");
    rd(4'h8, 8'h20, "R4 century loaded");

    // R4 writes ignored without load bit
    wr(4'hA, 8'h45);
    rd(4'hA, 8'h00, "R4 min ignored");
    wr(4'h8, 8'h15);
    rd(4'h8, 8'h20, "R4 century ignored");

    // R6 freeze
    wr(4'h8, 8'h40);
    rd(4'h8, 8'h60, "R6 freeze bit");
    ticks(2 * SUBTICKS);
    rd(4'h9, 8'h00, "R6 frozen");
    wr(4'h8, 8'h00);
    rd(4'h9, 8'h00, "R6 not yet refreshed");
    ticks(SUBTICKS);
    rd(4'h9, 8'h03, "R6 refreshed live count");

    // R9 leap rules
    set_and_step(8'h20, 8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    rd(4'hD, 8'h01, "R9 non-leap date");
    rd(4'hE, 8'h03, "R9 non-leap month");
    set_and_step(8'h19, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    rd(4'hE, 8'h03, "R9 century 19 year 00");
    set_and_step(8'h20, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    rd(4'hD, 8'h29, "R9 century 20 year 00");
    set_and_step(8'h20, 8'h12, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59);
    rd(4'hD, 8'h01, "R9 feb 29 end");
    rd(4'hE, 8'h03, "R9 feb 29 month");

    // R8 month lengths
    set_and_step(8'h20, 8'h21, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    rd(4'hD, 8'h01, "R8 april end");
    rd(4'hE, 8'h05, "R8 april month");
    set_and_step(8'h20, 8'h21, 8'h01, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    rd(4'hD, 8'h31, "R8 january 31");
    rd(4'hE, 8'h01, "R8 january held");

    // R7 carries
    set_and_step(8'h20, 8'h21, 8'h05, 8'h10, 8'h07, 8'h23, 8'h59, 8'h59);
    rd(4'hC, 8'h01, "R7 dow wrap");
    set_and_step(8'h20, 8'h21, 8'h05, 8'h10, 8'h03, 8'h09, 8'h09, 8'h59);
    rd(4'hA, 8'h10, "R7 min bcd carry");
    rd(4'hB, 8'h09, "R7 hour held");
    rd(4'h9, 8'h00, "R7 sec wrap");

    // R10 year and century
    set_and_step(8'h19, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    rd(4'h8, 8'h20, "R10 century inc");
    rd(4'hF, 8'h00, "R10 year wrap");
    rd(4'hE, 8'h01, "R10 month wrap");
    rd(4'hD, 8'h01, "R10 date wrap");
    set_and_step(8'h39, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    rd(4'h8, 8'h00, "R10 century wrap");
    set_and_step(8'h20, 8'h09, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    rd(4'hF, 8'h10, "R10 year bcd carry");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule